// File: doc/BRIEF.md
# SRAM Scrambling Key Controller

This block owns the key and nonce that an SRAM scrambling datapath uses, and exposes a small set of control and status registers through a single-cycle 32-bit register port. When software asks for a renewal, the block requests a fresh 128-bit key and 64-bit nonce from a key provider that runs on its own, slower clock. The request and the acknowledge cross the two domains through a four-phase handshake, and each direction has a synchroniser. The provider holds its key, nonce and seed flag steady while its acknowledge is high, so the main domain can take them as a whole word.

While a renewal is in flight, and for ever after an escalation, the block gates memory traffic. A gated request gets an error response and is not forwarded. An escalation also returns the key and nonce to their compile-time defaults. An uncorrectable integrity error reported by the memory sets a sticky flag. The byte address of each such error is captured, and the alert output stays high from then until reset. A lock register can freeze the control register.

Register map, by word index on `regIdx`: 0 status (read-only), 1 lock, 2 control, 3 error address (read-only).

Top module: `sram_key_ctrl`

## Requirements
- R1: After reset the status word reads 0, the lock reads 1, the error address reads 0, `alert` and `gate` are low, and `scrKey`/`scrNonce` equal the parameters `KeyRst`/`NonceRst`.
- R2: The status word (index 0) holds the sticky error flag in bit 0, the escalated flag in bit 1, key-valid in bit 2 and seed-valid in bit 3. All other bits read 0.
- R3: A write of exactly 1 to the control word (index 2) starts a renewal if all of these hold: the lock is 1, no renewal is pending, and the block is not escalated. One cycle later, key-valid reads 0 and `gate` is high.
- R4: When a renewal completes, `scrKey`/`scrNonce` carry the provider's key and nonce, key-valid reads 1, and seed-valid equals the provider's `provSeedOk`. `gate` then falls.
- R5: A control write that arrives while a renewal is pending has no effect, so the provider sees exactly one request per accepted renewal.
- R6: The lock word (index 1) reads 1 in bit 0 after reset. Writing exactly 1 clears it, and only reset sets it again. While the lock is 0, control writes start nothing.
- R7: Writes to the lock or control word that set any bit other than bit 0 are ignored. The control word always reads 0.
- R8: A cycle with `integErr` high sets status bit 0 on the next cycle, and it stays set until reset. Each such cycle loads `integErrAddr` into the error address word (index 3), so the last error wins.
- R9: `alert` is high on every cycle after the first integrity error, until reset.
- R10: A cycle with `escIn` high sets the escalated flag permanently, clears key-valid and seed-valid, returns the key and nonce to their defaults, and keeps `gate` high from then on.
- R11: While `gate` is high, `memReq` yields `memErrRsp` and no `memFwd`. While `gate` is low, `memFwd` follows `memReq` and `memErrRsp` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Main domain reset, active low |
| provClk | input | 1 | Key provider clock |
| provRstN | input | 1 | Key provider domain reset, active low |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 2 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the word at `regIdx` |
| provReq | output | 1 | Key request, provider clock domain |
| provAck | input | 1 | Key acknowledge from the provider |
| provKey | input | 128 | Key from the provider, stable while `provAck` is high |
| provNonce | input | 64 | Nonce from the provider, stable while `provAck` is high |
| provSeedOk | input | 1 | Seed-valid flag from the provider |
| escIn | input | 1 | Escalation request |
| integErr | input | 1 | Uncorrectable integrity error strobe |
| integErrAddr | input | 32 | Byte address of the failing access |
| memReq | input | 1 | Incoming memory request |
| memFwd | output | 1 | Request forwarded to memory |
| memErrRsp | output | 1 | Request answered with an error |
| gate | output | 1 | Memory traffic blocked |
| alert | output | 1 | Integrity alert, held high |
| scrKey | output | 128 | Scrambling key |
| scrNonce | output | 64 | Scrambling nonce |

## Verification
The renewal path is run several times in a row, and the provider returns a different key, nonce and seed flag on each run. This separates stale captures from fresh ones and shows that seed-valid follows the provider rather than a constant. Each run also repeats the control write mid-flight and probes `memReq` both while gated and after the gate falls. This separates ignored duplicate requests from restarted ones. Error strobes go through a sweep of distinct addresses to show that the last one wins. Lock and reserved-bit writes are then shown to start nothing, and a final escalation is shown to wipe a valid key back to the defaults.

// File: rtl/sram_key_pkg.sv
package sram_key_pkg;
  localparam int RegW = 32;
  localparam logic [1:0] IdxStatus = 2'd0;
  localparam logic [1:0] IdxLock   = 2'd1;
  localparam logic [1:0] IdxCtrl   = 2'd2;
  localparam logic [1:0] IdxErrAdr = 2'd3;

  typedef struct packed {
    logic loadKey;
    logic wipeKey;
    logic clrSeed;
    logic capErr;
  } dpStrobe_t;
endpackage

// File: rtl/skc_sync.sv
module skc_sync #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [Stages-1:0] chain;

  for (genvar i = 0; i < Stages; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[Stages-1];
endmodule

// File: rtl/skc_ctrl.sv
module skc_ctrl
  import sram_key_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWe,
  input  logic [1:0] regIdx,
  input  logic      wrBit0,
  input  logic      wrRsvdZero,
  input  logic      escIn,
  input  logic      integErr,
  input  logic      ackLvl,
  output logic      reqOut,
  output dpStrobe_t strobe,
  output logic      keyValid,
  output logic      escalated,
  output logic      errSticky,
  output logic      lockOpen,
  output logic      gate
);
  logic reqQ, ackQ, keyValidQ, escQ, errQ, lockQ;
  logic pending, wrOk, renewHit, lockClr, ackRise, escNow;

  assign wrOk     = regWe && wrRsvdZero && wrBit0;
  assign pending  = reqQ | ackLvl;
  assign escNow   = escIn | escQ;
  assign renewHit = wrOk && (regIdx == IdxCtrl) && lockQ && !pending && !escQ;
  assign lockClr  = wrOk && (regIdx == IdxLock);
  assign ackRise  = ackLvl & ~ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ      <= 1'b0;
      ackQ      <= 1'b0;
      keyValidQ <= 1'b0;
      escQ      <= 1'b0;
      errQ      <= 1'b0;
      lockQ     <= 1'b1;
    end else begin
      ackQ <= ackLvl;
      if (renewHit)     reqQ <= 1'b1;
      else if (ackRise) reqQ <= 1'b0;
      if (escNow || renewHit) keyValidQ <= 1'b0;
      else if (ackRise)       keyValidQ <= 1'b1;
      if (escIn)    escQ  <= 1'b1;
      if (integErr) errQ  <= 1'b1;
      if (lockClr)  lockQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.loadKey = ackRise && !escNow;
    strobe.wipeKey = escNow;
    strobe.clrSeed = renewHit;
    strobe.capErr  = integErr;
  end

  assign reqOut    = reqQ;
  assign keyValid  = keyValidQ;
  assign escalated = escQ;
  assign errSticky = errQ;
  assign lockOpen  = lockQ;
  assign gate      = pending | escQ;

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);
  a_r10_esc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    escQ |=> (escQ && gate && !keyValidQ));
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !lockQ |=> !lockQ);
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rstN)
    reqQ |=> (reqQ || ackQ));
  a_r3_renew_clears_valid: assert property (@(posedge clk) disable iff (!rstN)
    renewHit |=> (!keyValidQ && gate));
endmodule

// File: rtl/skc_datapath.sv
module skc_datapath
  import sram_key_pkg::*;
#(
  parameter int KeyW   = 128,
  parameter int NonceW = 64,
  parameter logic [KeyW-1:0]   KeyRst   = '0,
  parameter logic [NonceW-1:0] NonceRst = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [KeyW-1:0]   provKey,
  input  logic [NonceW-1:0] provNonce,
  input  logic              provSeedOk,
  input  logic [RegW-1:0]   integErrAddr,
  output logic [KeyW-1:0]   keyOut,
  output logic [NonceW-1:0] nonceOut,
  output logic              seedValid,
  output logic [RegW-1:0]   errAddr
);
  logic [KeyW-1:0]   keyQ;
  logic [NonceW-1:0] nonceQ;
  logic              seedQ;
  logic [RegW-1:0]   errAddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ     <= KeyRst;
      nonceQ   <= NonceRst;
      seedQ    <= 1'b0;
      errAddrQ <= '0;
    end else begin
      if (strobe.wipeKey) begin
        keyQ   <= KeyRst;
        nonceQ <= NonceRst;
        seedQ  <= 1'b0;
      end else if (strobe.loadKey) begin
        keyQ   <= provKey;
        nonceQ <= provNonce;
        seedQ  <= provSeedOk;
      end else if (strobe.clrSeed) begin
        seedQ  <= 1'b0;
      end
      if (strobe.capErr) errAddrQ <= integErrAddr;
    end
  end

  assign keyOut    = keyQ;
  assign nonceOut  = nonceQ;
  assign seedValid = seedQ;
  assign errAddr   = errAddrQ;

  a_r10_wipe_default: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipeKey |=> (keyQ == KeyRst && nonceQ == NonceRst && !seedQ));
  a_r8_addr_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capErr |=> (errAddrQ == $past(integErrAddr)));
  a_r4_key_load: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadKey && !strobe.wipeKey) |=> (keyQ == $past(provKey)));
endmodule

// File: rtl/sram_key_ctrl.sv
module sram_key_ctrl
  import sram_key_pkg::*;
#(
  parameter int KeyW       = 128,
  parameter int NonceW     = 64,
  parameter int SyncStages = 2,
  parameter logic [KeyW-1:0]   KeyRst   = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0,
  parameter logic [NonceW-1:0] NonceRst = 64'h13579BDF_2468ACE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              provClk,
  input  logic              provRstN,
  input  logic              regWe,
  input  logic [1:0]        regIdx,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              provReq,
  input  logic              provAck,
  input  logic [KeyW-1:0]   provKey,
  input  logic [NonceW-1:0] provNonce,
  input  logic              provSeedOk,
  input  logic              escIn,
  input  logic              integErr,
  input  logic [31:0]       integErrAddr,
  input  logic              memReq,
  output logic              memFwd,
  output logic              memErrRsp,
  output logic              gate,
  output logic              alert,
  output logic [KeyW-1:0]   scrKey,
  output logic [NonceW-1:0] scrNonce
);
  dpStrobe_t strobe;
  logic reqMain, ackLvl, keyValid, escalated, errSticky, lockOpen, seedValid;
  logic [RegW-1:0] errAddr;

  skc_sync #(.Stages(SyncStages)) u_req_sync (
    .clk(provClk), .rstN(provRstN), .d(reqMain), .q(provReq));
  skc_sync #(.Stages(SyncStages)) u_ack_sync (
    .clk(clk), .rstN(rstN), .d(provAck), .q(ackLvl));

  skc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx),
    .wrBit0(regWdata[0]), .wrRsvdZero(regWdata[31:1] == '0),
    .escIn(escIn), .integErr(integErr), .ackLvl(ackLvl),
    .reqOut(reqMain), .strobe(strobe), .keyValid(keyValid),
    .escalated(escalated), .errSticky(errSticky), .lockOpen(lockOpen),
    .gate(gate));

  skc_datapath #(.KeyW(KeyW), .NonceW(NonceW), .KeyRst(KeyRst),
                 .NonceRst(NonceRst)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .provKey(provKey),
    .provNonce(provNonce), .provSeedOk(provSeedOk),
    .integErrAddr(integErrAddr), .keyOut(scrKey), .nonceOut(scrNonce),
    .seedValid(seedValid), .errAddr(errAddr));

  always_comb begin
    unique case (regIdx)
      IdxStatus: regRdata = {28'd0, seedValid, keyValid, escalated, errSticky};
      IdxLock:   regRdata = {31'd0, lockOpen};
      IdxCtrl:   regRdata = '0;
      default:   regRdata = errAddr;
    endcase
  end

  assign memFwd    = memReq & ~gate;
  assign memErrRsp = memReq & gate;
  assign alert     = errSticky;

  a_r11_gated_no_forward: assert property (@(posedge clk) disable iff (!rstN)
    gate |-> (!memFwd && (memErrRsp == memReq)));
  a_r9_alert_held: assert property (@(posedge clk) disable iff (!rstN)
    integErr |=> alert);
endmodule

// File: tb/sram_key_ctrl_tb_top.sv
module sram_key_ctrl_tb_top;
  localparam logic [127:0] TbKeyRst   = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
  localparam logic [63:0]  TbNonceRst = 64'h13579BDF_2468ACE0;

  logic clk = 0, provClk = 0, rstN = 0, provRstN = 0;
  logic regWe = 0;
  logic [1:0] regIdx = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic provReq, provAck = 0, provSeedOk = 0;
  logic [127:0] provKey = 0, scrKey;
  logic [63:0] provNonce = 0, scrNonce;
  logic escIn = 0, integErr = 0, memReq = 0;
  logic [31:0] integErrAddr = 0;
  logic memFwd, memErrRsp, gate, alert;

  int vectors = 0, miscompares = 0, reqCount = 0;
  bit summaryDone = 0;

  always #5 clk = ~clk;
  always #13 provClk = ~provClk;

  sram_key_ctrl #(.KeyRst(TbKeyRst), .NonceRst(TbNonceRst)) dut_i (
    .clk(clk), .rstN(rstN), .provClk(provClk), .provRstN(provRstN),
    .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata), .regRdata(regRdata),
    .provReq(provReq), .provAck(provAck), .provKey(provKey),
    .provNonce(provNonce), .provSeedOk(provSeedOk), .escIn(escIn),
    .integErr(integErr), .integErrAddr(integErrAddr), .memReq(memReq),
    .memFwd(memFwd), .memErrRsp(memErrRsp), .gate(gate), .alert(alert),
    .scrKey(scrKey), .scrNonce(scrNonce));

  function automatic logic [127:0] keyOf(int n);
    return {32'hC0DE0000 + n, 32'hBEEF0000 + n, 32'h12340000 + n, 32'h00005678 + n};
  endfunction
  function automatic logic [63:0] nonceOf(int n);
    return {32'hFACE0000 + n, 32'h0000A000 + n};
  endfunction

  // key provider model, provider clock domain
  initial begin
    forever begin
      @(negedge provClk);
      if (provReq && !provAck) begin
        reqCount++;
        repeat (3) @(negedge provClk);
        provKey    = keyOf(reqCount);
        provNonce  = nonceOf(reqCount);
        provSeedOk = reqCount[0];
        provAck    = 1;
      end else if (!provReq && provAck) begin
        provAck = 0;
      end
    end
  end

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] idx, logic [31:0] d);
    @(negedge clk);
    regWe = 1; regIdx = idx; regWdata = d;
    @(negedge clk);
    regWe = 0; regWdata = 0;
  endtask

  task automatic rd(logic [1:0] idx, output logic [31:0] v);
    regIdx = idx;
    #1;
    v = regRdata;
  endtask

  task automatic memProbe(string req, logic expGate);
    memReq = 1;
    #1;
    chk(req, {memFwd, memErrRsp, gate}, {!expGate, expGate, expGate});
    memReq = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1; provRstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 lock", v, 1);
    rd(3, v); chk("R1 erraddr", v, 0);
    rd(2, v); chk("R7 ctrl reads 0", v, 0);
    chk("R1 key/nonce", {scrKey, scrNonce[63:0]} >> 64, {64'd0, TbKeyRst} );
    chk("R1 nonce", scrNonce, TbNonceRst);
    chk("R9 alert low at reset", alert, 0);
    memProbe("R11 ungated at reset", 0);

    // R3/R4/R5 renewal sweep with varying provider values
    for (int n = 1; n <= 4; n++) begin
      wr(2, 32'h1);
      rd(0, v); chk("R3 key-valid cleared", v[2], 0);
      chk("R3 gate high", gate, 1);
      memProbe("R11 gated during renewal", 1);
      wr(2, 32'h1);
      for (int t = 0; t < 400 && gate; t++) @(negedge clk);
      chk("R4 gate dropped", gate, 0);
      chk("R4 key", scrKey, keyOf(n));
      chk("R4 nonce", scrNonce, nonceOf(n));
      rd(0, v); chk("R2 R4 status", v, {28'd0, n[0], 1'b1, 2'b00});
      chk("R5 one request each", reqCount, n);
      memProbe("R11 forwarded after renewal", 0);
      rd(2, v); chk("R7 ctrl reads 0", v, 0);
    end

    // R7 reserved bits drop the write
    wr(2, 32'h3);
    repeat (60) @(negedge clk);
    chk("R7 no request on rsvd write", reqCount, 4);
    wr(1, 32'h8000_0001);
    rd(1, v); chk("R7 lock kept on rsvd write", v, 1);

    // R8/R9 error address sweep
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      integErr = 1; integErrAddr = 32'h0000_1000 + i * 32'h144;
      @(negedge clk);
      integErr = 0;
      rd(3, v); chk("R8 error address", v, 32'h0000_1000 + i * 32'h144);
      rd(0, v); chk("R8 error flag", v[0], 1);
      chk("R9 alert", alert, 1);
    end
    repeat (5) @(negedge clk);
    rd(0, v); chk("R8 error sticky", v[0], 1);
    chk("R9 alert held", alert, 1);

    // R6 lock
    wr(1, 32'h0);
    rd(1, v); chk("R6 write 0 no effect", v, 1);
    wr(1, 32'h1);
    rd(1, v); chk("R6 lock cleared", v, 0);
    wr(1, 32'h1);
    rd(1, v); chk("R6 lock stays clear", v, 0);
    wr(2, 32'h1);
    repeat (60) @(negedge clk);
    chk("R6 locked renew ignored", reqCount, 4);
    rd(0, v); chk("R6 key still valid", v[2], 1);

    // R10 escalation
    @(negedge clk); escIn = 1;
    @(negedge clk); escIn = 0;
    rd(0, v); chk("R10 escalated status", v[3:1], 3'b001);
    chk("R10 key default", scrKey, TbKeyRst);
    chk("R10 nonce default", scrNonce, TbNonceRst);
    memProbe("R10 R11 gated after escalation", 1);
    repeat (10) @(negedge clk);
    rd(0, v); chk("R10 escalation terminal", v[3:1], 3'b001);
    memProbe("R10 still gated", 1);

    summary();
    $finish;
  end
endmodule